// File: doc/BRIEF.md
# BCD Real-Time Clock Calendar with Frozen-Copy Readout

This block keeps wall-clock time and date as packed BCD fields: seconds, minutes, hours (24-hour), day of month, month, a two-digit year counting from 2000, and a weekday. A prescaler divides a 32.768 kHz enable pulse into one-second steps. The calendar logic carries each field into the next and applies month lengths, including leap Februaries.

Software reaches the block over a byte-wide register bus with address, write data, write strobe, read strobe and a registered read-data output. A control byte holds three settings. One bit halts counting so a new time can be loaded. Another bit requests a frozen copy of every field, taken on a single 32 kHz step. A third bit chooses whether time reads return the running counters or that frozen copy. Reading back through the frozen copy gives a coherent time, because no field can roll over between the reads of two bytes.

Top module: `bcd_rtc_top`

Register map: time fields at addresses 0x0 seconds, 0x1 minutes, 0x2 hours, 0x3 day, 0x4 month, 0x5 year, 0x6 weekday. Control is at 0x8 and status at 0x9. All other addresses read 0x00. Read data appears on `rdata` in the cycle after the one in which `rd_en` is sampled high.

## Requirements
- R1: After reset the time reads 2000-01-01 00:00:00 with weekday 6. Control reads 0x00 and status reads 0x01.
- R2: A write to a time address loads the running counter at once, keeping only the field's significant bits. The kept bits are seconds [6:0], minutes [6:0], hours [5:0], day [5:0], month [4:0], year [7:0] and weekday [2:0]. The other bits read back as 0.
- R3: Seconds advance once for every 2^PRESC_W accepted 32 kHz pulses. Seconds go 59 to 00 and carry into minutes, minutes go 59 to 00 and carry into hours, and hours go 23 to 00 and carry into the day. All of these steps are in BCD.
- R4: The last day is 30 for months 04, 06, 09 and 11, and 31 for months 01, 03, 05, 07, 08, 10 and 12. After the last day the day returns to 01 and the month advances. November 30 is followed by December 01.
- R5: February ends on day 29 when the BCD year is a multiple of 4, including 00. Otherwise it ends on day 28.
- R6: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.
- R7: The weekday advances on every day rollover and wraps from 6 to 0, so counting never produces 7.
- R8: While control bit 0 (stop) is 1, no field advances and the prescaler is held at zero. After stop is cleared, the first second step comes on the 2^PRESC_W-th pulse.
- R9: Writing control with bit 6 set requests a frozen copy. The status bit 0 reads 0 while the request is pending. On the next 32 kHz pulse all seven live fields are copied together, as they were just before that pulse, and the status bit returns to 1. Control bit 6 always reads 0.
- R10: When control bit 7 is 1, reads of addresses 0x0 to 0x6 return the frozen copy. When it is 0, they return the live counters. Control reads back with bit 7 as the read-select setting and bit 0 as stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_32k | input | 1 | One-cycle enable pulse per 32.768 kHz period |
| addr | input | ADDR_W (4) | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |

## Verification
The assertions check these behaviours on every cycle:
- a pending frozen copy completes on the next pulse and holds the live values from just before that pulse;
- reads with read-select set return the frozen copy;
- no second step is produced while stop is set;
- a day rollover in November happens only from day 30;
- weekday 6 wraps to 0.

The bench scenarios are what show calendar arithmetic that needs chosen starting dates. These include the leap and non-leap Februaries, the month lengths, the year wrap from 99, bit masking on writes, and the exact pulse count to the first second after a resume.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;

  localparam int unsigned N_FIELDS  = 7;
  localparam int unsigned ADR_SEC   = 0;
  localparam int unsigned ADR_MIN   = 1;
  localparam int unsigned ADR_HOUR  = 2;
  localparam int unsigned ADR_DAY   = 3;
  localparam int unsigned ADR_MON   = 4;
  localparam int unsigned ADR_YEAR  = 5;
  localparam int unsigned ADR_WDAY  = 6;
  localparam int unsigned ADR_CTRL  = 8;
  localparam int unsigned ADR_STAT  = 9;
  localparam int unsigned BIT_STOP  = 0;
  localparam int unsigned BIT_SNAP  = 6;
  localparam int unsigned BIT_RSEL  = 7;

  typedef struct packed {
    logic [7:0] year;
    logic [4:0] mon;
    logic [5:0] day;
    logic [5:0] hour;
    logic [6:0] min;
    logic [6:0] sec;
    logic [2:0] wday;
  } rtc_time_t;

  localparam rtc_time_t TIME_AT_RESET = '{year: 8'h00, mon: 5'h01, day: 6'h01,
                                          hour: 6'h00, min: 7'h00, sec: 7'h00,
                                          wday: 3'd6};

  // Two-digit BCD increment; callers wrap before the upper digit overflows.
  function automatic logic [7:0] bcd_step(input logic [7:0] v);
    if (v[3:0] == 4'h9) bcd_step = {v[7:4] + 4'h1, 4'h0};
    else                bcd_step = {v[7:4], v[3:0] + 4'h1};
  endfunction

  // Multiple of 4: even tens with units 0/4/8, or odd tens with units 2/6.
  function automatic logic year_is_leap(input logic [7:0] y);
    if (y[4]) year_is_leap = (y[3:0] == 4'h2) || (y[3:0] == 4'h6);
    else      year_is_leap = (y[3:0] == 4'h0) || (y[3:0] == 4'h4) || (y[3:0] == 4'h8);
  endfunction

  function automatic logic [5:0] month_end(input logic [4:0] m, input logic [7:0] y);
    case (m)
      5'h02:                      month_end = year_is_leap(y) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: month_end = 6'h30;
      default:                    month_end = 6'h31;
    endcase
  endfunction

  function automatic logic [7:0] field_byte(input rtc_time_t t, input logic [2:0] idx);
    case (idx)
      3'd0:    field_byte = {1'b0, t.sec};
      3'd1:    field_byte = {1'b0, t.min};
      3'd2:    field_byte = {2'b0, t.hour};
      3'd3:    field_byte = {2'b0, t.day};
      3'd4:    field_byte = {3'b0, t.mon};
      3'd5:    field_byte = t.year;
      3'd6:    field_byte = {5'b0, t.wday};
      default: field_byte = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/bcd_rtc_prescaler.sv
module bcd_rtc_prescaler #(
  parameter int unsigned PRESC_W = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic hold,
  output logic sec_tick
);

  logic [PRESC_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (hold)      cnt_d = '0;
    else if (tick) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign sec_tick = tick && !hold && (cnt_q == {PRESC_W{1'b1}});

endmodule

// File: rtl/bcd_rtc_calendar.sv
module bcd_rtc_calendar
  import bcd_rtc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sec_tick,
  input  logic [N_FIELDS-1:0] fld_we,
  input  logic [7:0]          wdata,
  output rtc_time_t           now,
  output logic                day_carry
);

  rtc_time_t  now_q, now_d;
  logic       min_carry, hour_carry, mon_carry, year_carry;
  logic [7:0] sec_nx, min_nx, hour_nx, day_nx, mon_nx, year_nx;
  logic [5:0] last_day;

  assign sec_nx   = bcd_step({1'b0, now_q.sec});
  assign min_nx   = bcd_step({1'b0, now_q.min});
  assign hour_nx  = bcd_step({2'b0, now_q.hour});
  assign day_nx   = bcd_step({2'b0, now_q.day});
  assign mon_nx   = bcd_step({3'b0, now_q.mon});
  assign year_nx  = bcd_step(now_q.year);
  assign last_day = month_end(now_q.mon, now_q.year);

  assign min_carry  = sec_tick   && (now_q.sec  == 7'h59);
  assign hour_carry = min_carry  && (now_q.min  == 7'h59);
  assign day_carry  = hour_carry && (now_q.hour == 6'h23);
  assign mon_carry  = day_carry  && (now_q.day  == last_day);
  assign year_carry = mon_carry  && (now_q.mon  == 5'h12);

  always_comb begin
    now_d = now_q;
    if (sec_tick)   now_d.sec  = (now_q.sec  == 7'h59) ? 7'h00 : sec_nx[6:0];
    if (min_carry)  now_d.min  = (now_q.min  == 7'h59) ? 7'h00 : min_nx[6:0];
    if (hour_carry) now_d.hour = (now_q.hour == 6'h23) ? 6'h00 : hour_nx[5:0];
    if (day_carry) begin
      now_d.day  = (now_q.day == last_day) ? 6'h01 : day_nx[5:0];
      now_d.wday = (now_q.wday >= 3'd6) ? 3'd0 : now_q.wday + 3'd1;
    end
    if (mon_carry)  now_d.mon  = (now_q.mon  == 5'h12) ? 5'h01 : mon_nx[4:0];
    if (year_carry) now_d.year = (now_q.year == 8'h99) ? 8'h00 : year_nx;
    if (fld_we[ADR_SEC])  now_d.sec  = wdata[6:0];
    if (fld_we[ADR_MIN])  now_d.min  = wdata[6:0];
    if (fld_we[ADR_HOUR]) now_d.hour = wdata[5:0];
    if (fld_we[ADR_DAY])  now_d.day  = wdata[5:0];
    if (fld_we[ADR_MON])  now_d.mon  = wdata[4:0];
    if (fld_we[ADR_YEAR]) now_d.year = wdata;
    if (fld_we[ADR_WDAY]) now_d.wday = wdata[2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) now_q <= TIME_AT_RESET;
    else        now_q <= now_d;
  end

  assign now = now_q;

endmodule

// File: rtl/bcd_rtc_regs.sv
module bcd_rtc_regs
  import bcd_rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [7:0]          wdata,
  input  logic                wr_en,
  input  logic                rd_en,
  input  rtc_time_t           live,
  output logic [N_FIELDS-1:0] fld_we,
  output logic                stop,
  output logic                rsel,
  output logic                snap_pend,
  output rtc_time_t           shadow,
  output logic [7:0]          rdata
);

  logic      stop_q, stop_d, rsel_q, rsel_d, pend_q, pend_d;
  rtc_time_t shad_q, shad_d, src;
  logic [7:0] rdata_q, rdata_d;
  logic       ctrl_we;

  genvar g;
  generate
    for (g = 0; g < N_FIELDS; g++) begin : g_fld_we
      assign fld_we[g] = wr_en && (addr == ADDR_W'(g));
    end
  endgenerate

  assign ctrl_we = wr_en && (addr == ADDR_W'(ADR_CTRL));
  assign src     = rsel_q ? shad_q : live;

  always_comb begin
    stop_d = stop_q;
    rsel_d = rsel_q;
    pend_d = pend_q;
    shad_d = shad_q;
    if (pend_q && tick) begin
      shad_d = live;
      pend_d = 1'b0;
    end
    if (ctrl_we) begin
      stop_d = wdata[BIT_STOP];
      rsel_d = wdata[BIT_RSEL];
      if (wdata[BIT_SNAP]) pend_d = 1'b1;
    end
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) begin
      if (addr < ADDR_W'(N_FIELDS))          rdata_d = field_byte(src, addr[2:0]);
      else if (addr == ADDR_W'(ADR_CTRL))    rdata_d = {rsel_q, 6'b0, stop_q};
      else if (addr == ADDR_W'(ADR_STAT))    rdata_d = {7'b0, !pend_q};
      else                                   rdata_d = 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q  <= 1'b0;
      rsel_q  <= 1'b0;
      pend_q  <= 1'b0;
      shad_q  <= TIME_AT_RESET;
      rdata_q <= 8'h00;
    end else begin
      stop_q  <= stop_d;
      rsel_q  <= rsel_d;
      pend_q  <= pend_d;
      shad_q  <= shad_d;
      rdata_q <= rdata_d;
    end
  end

  assign stop      = stop_q;
  assign rsel      = rsel_q;
  assign snap_pend = pend_q;
  assign shadow    = shad_q;
  assign rdata     = rdata_q;

endmodule

// File: rtl/bcd_rtc_top.sv
module bcd_rtc_top
  import bcd_rtc_pkg::*;
#(
  parameter int unsigned PRESC_W = 15,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_32k,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [7:0]        rdata
);

  logic [1:0]          rst_sync_q;
  logic                rst_n_int;
  logic                sec_tick, day_carry, stop, rsel, snap_pend;
  logic [N_FIELDS-1:0] fld_we;
  rtc_time_t           live, shadow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  bcd_rtc_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .tick     (tick_32k),
    .hold     (stop),
    .sec_tick (sec_tick)
  );

  bcd_rtc_calendar u_cal (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .sec_tick  (sec_tick),
    .fld_we    (fld_we),
    .wdata     (wdata),
    .now       (live),
    .day_carry (day_carry)
  );

  bcd_rtc_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .tick      (tick_32k),
    .addr      (addr),
    .wdata     (wdata),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .live      (live),
    .fld_we    (fld_we),
    .stop      (stop),
    .rsel      (rsel),
    .snap_pend (snap_pend),
    .shadow    (shadow),
    .rdata     (rdata)
  );

endmodule

// File: rtl/bcd_rtc_chk.sv
module bcd_rtc_chk
  import bcd_rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              sec_tick,
  input logic              stop,
  input logic              day_carry,
  input logic              snap_pend,
  input logic              rsel,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic [7:0]        rdata,
  input rtc_time_t         live,
  input rtc_time_t         shadow
);

  logic snap_rearm;
  assign snap_rearm = wr_en && (addr == ADDR_W'(ADR_CTRL)) && wdata[BIT_SNAP];

  AST_STOP_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    stop |-> !sec_tick); // R8

  AST_NOV_LAST_30: assert property (@(posedge clk) disable iff (!rst_n)
    (day_carry && live.mon == 5'h11) |-> (live.day <= 6'h30)); // R4

  AST_WDAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (day_carry && live.wday == 3'd6 && !(wr_en && addr == ADDR_W'(ADR_WDAY)))
    |=> (live.wday == 3'd0)); // R7

  AST_SNAP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_pend && tick && !snap_rearm) |=> !snap_pend); // R9

  AST_SNAP_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_pend && tick) |=> (shadow == $past(live))); // R9

  AST_RSEL_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rsel && addr == ADDR_W'(ADR_SEC)) |=> (rdata == {1'b0, $past(shadow.sec)})); // R10

endmodule

bind bcd_rtc_top bcd_rtc_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_int),
  .tick      (tick_32k),
  .sec_tick  (sec_tick),
  .stop      (stop),
  .day_carry (day_carry),
  .snap_pend (snap_pend),
  .rsel      (rsel),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .addr      (addr),
  .wdata     (wdata),
  .rdata     (rdata),
  .live      (live),
  .shadow    (shadow)
);

// File: tb/bcd_rtc_top_tb.sv
module bcd_rtc_top_tb;

  localparam int unsigned PW   = 3;
  localparam int unsigned STEP = 1 << PW;

  logic       clk, rst_n, tick_32k, wr_en, rd_en;
  logic [3:0] addr;
  logic [7:0] wdata, rdata;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  bcd_rtc_top #(.PRESC_W(PW), .ADDR_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .addr(addr),
    .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Monitor: pops one expected byte per sampled read strobe.
  initial begin
    forever begin
      @(posedge clk);
      if (rd_en) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL scoreboard: read with no expected item, actual %h", rdata);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          n_chk++;
          if (rdata !== e) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", t, rdata, e);
          end
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
    @(negedge clk); addr = a; rd_en = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_32k = 1'b1;
      @(negedge clk); tick_32k = 1'b0;
    end
  endtask

  task automatic set_time(input logic [7:0] y, mo, d, h, mi, s, wd);
    wr(4'h8, 8'h01);
    wr(4'h0, s); wr(4'h1, mi); wr(4'h2, h); wr(4'h3, d);
    wr(4'h4, mo); wr(4'h5, y); wr(4'h6, wd);
    wr(4'h8, 8'h00);
  endtask

  task automatic chk_time(input logic [7:0] y, mo, d, h, mi, s, wd, input string t);
    rd(4'h0, s, t); rd(4'h1, mi, t); rd(4'h2, h, t); rd(4'h3, d, t);
    rd(4'h4, mo, t); rd(4'h5, y, t); rd(4'h6, wd, t);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick_32k = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk_time(8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h06, "R1 reset time");
    rd(4'h8, 8'h00, "R1 reset ctrl");
    rd(4'h9, 8'h01, "R1 reset status");

    // R2 masking and direct load
    wr(4'h8, 8'h01);
    wr(4'h0, 8'hFF); rd(4'h0, 8'h7F, "R2 sec mask");
    wr(4'h2, 8'hFF); rd(4'h2, 8'h3F, "R2 hour mask");
    wr(4'h3, 8'hFF); rd(4'h3, 8'h3F, "R2 day mask");
    wr(4'h4, 8'hFF); rd(4'h4, 8'h1F, "R2 month mask");
    wr(4'h6, 8'hFF); rd(4'h6, 8'h07, "R2 wday mask");
    wr(4'h5, 8'h47); rd(4'h5, 8'h47, "R2 year load");
    rd(4'hC, 8'h00, "R2 unmapped");

    // R3 carries
    set_time(8'h05, 8'h03, 8'h14, 8'h12, 8'h34, 8'h59, 8'h02);
    pulses(STEP - 1);
    rd(4'h0, 8'h59, "R3 no step before full count");
    pulses(1);
    chk_time(8'h05, 8'h03, 8'h14, 8'h12, 8'h35, 8'h00, 8'h02, "R3 minute carry");
    set_time(8'h05, 8'h03, 8'h14, 8'h09, 8'h59, 8'h59, 8'h02);
    pulses(STEP);
    chk_time(8'h05, 8'h03, 8'h14, 8'h10, 8'h00, 8'h00, 8'h02, "R3 hour bcd carry");

    // R3 / R7 day rollover with weekday 6 -> 0
    set_time(8'h00, 8'h01, 8'h01, 8'h23, 8'h59, 8'h59, 8'h06);
    pulses(STEP);
    chk_time(8'h00, 8'h01, 8'h02, 8'h00, 8'h00, 8'h00, 8'h00, "R7 wday wrap");

    // R4 month lengths
    set_time(8'h23, 8'h11, 8'h30, 8'h23, 8'h59, 8'h59, 8'h03);
    pulses(STEP);
    chk_time(8'h23, 8'h12, 8'h01, 8'h00, 8'h00, 8'h00, 8'h04, "R4 nov30");
    set_time(8'h23, 8'h01, 8'h30, 8'h23, 8'h59, 8'h59, 8'h01);
    pulses(STEP);
    rd(4'h3, 8'h31, "R4 jan30"); rd(4'h4, 8'h01, "R4 jan30 month");
    set_time(8'h23, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59, 8'h00);
    pulses(STEP);
    rd(4'h3, 8'h01, "R4 apr30"); rd(4'h4, 8'h05, "R4 apr30 month");
    set_time(8'h23, 8'h09, 8'h30, 8'h23, 8'h59, 8'h59, 8'h05);
    pulses(STEP);
    rd(4'h3, 8'h01, "R4 sep30"); rd(4'h4, 8'h10, "R4 sep30 month");

    // R5 February
    set_time(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59, 8'h03);
    pulses(STEP);
    rd(4'h3, 8'h29, "R5 leap 24 feb28"); rd(4'h4, 8'h02, "R5 leap 24 month");
    set_time(8'h24, 8'h02, 8'h29, 8'h23, 8'h59, 8'h59, 8'h04);
    pulses(STEP);
    rd(4'h3, 8'h01, "R5 leap feb29"); rd(4'h4, 8'h03, "R5 leap feb29 month");
    set_time(8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59, 8'h02);
    pulses(STEP);
    rd(4'h3, 8'h01, "R5 nonleap 23"); rd(4'h4, 8'h03, "R5 nonleap 23 month");
    set_time(8'h12, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59, 8'h02);
    pulses(STEP);
    rd(4'h3, 8'h29, "R5 leap 12");
    set_time(8'h00, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59, 8'h01);
    pulses(STEP);
    rd(4'h3, 8'h29, "R5 leap 00");
    set_time(8'h10, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59, 8'h01);
    pulses(STEP);
    rd(4'h3, 8'h01, "R5 nonleap 10");

    // R6 year wrap
    set_time(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59, 8'h05);
    pulses(STEP);
    chk_time(8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h06, "R6 year 99 wrap");
    set_time(8'h19, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59, 8'h02);
    pulses(STEP);
    rd(4'h5, 8'h20, "R6 year bcd carry"); rd(4'h4, 8'h01, "R6 dec wrap");

    // R8 stop
    set_time(8'h01, 8'h06, 8'h15, 8'h08, 8'h00, 8'h10, 8'h01);
    pulses(3);
    wr(4'h8, 8'h01);
    rd(4'h8, 8'h01, "R8 ctrl stop readback");
    pulses(3 * STEP);
    rd(4'h0, 8'h10, "R8 held while stopped");
    wr(4'h8, 8'h00);
    pulses(STEP - 1);
    rd(4'h0, 8'h10, "R8 prescaler restarted");
    pulses(1);
    rd(4'h0, 8'h11, "R8 first step after resume");

    // R9 / R10 frozen copy
    set_time(8'h30, 8'h07, 8'h04, 8'h10, 8'h20, 8'h05, 8'h02);
    wr(4'h8, 8'hC0);
    rd(4'h9, 8'h00, "R9 status pending");
    rd(4'h8, 8'h80, "R9 ctrl snap bit reads 0");
    pulses(1);
    rd(4'h9, 8'h01, "R9 status done");
    pulses(STEP - 1);
    rd(4'h0, 8'h05, "R10 shadow seconds");
    rd(4'h2, 8'h10, "R10 shadow hours");
    rd(4'h5, 8'h30, "R10 shadow year");
    wr(4'h8, 8'h00);
    rd(4'h0, 8'h06, "R10 live seconds");
    rd(4'h8, 8'h00, "R10 ctrl cleared");

    repeat (4) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule